// File: doc/BRIEF.md
# Direct-Mode Clock Phase Programmer

This block sets the phase offset of a clock manager through its dynamic reconfiguration bus. A requester presents a tap count and a flag that says whether the manager already runs in direct phase mode. The block then performs the register writes in the required order on the reconfiguration bus, which runs in the DCLK domain. Each write waits for the bus to answer with ready before the next one is issued.

After the write that starts the shift, the block can wait for the manager's completion pulse. That pulse is one cycle wide in the phase clock domain. It is brought into the DCLK domain with a toggle synchronizer. A programmable timeout ends the wait for a phase clock that is absent or stalled, and a parameter removes the wait entirely for a manager whose phase clock is left unconnected. When the fine-step parameter is off, the shift logic works in groups of eight taps, so the three low tap bits are cleared before they are written.

Top module: `ps_direct_seq`

## Requirements
- R1: While reset is high, and on the first edge after it, busy, done, timeout and drp_en are all low.
- R2: When req_mode_ready is low, the first write of an accepted request puts data 0x000D at address 0x56. When it is high, that write is left out and the first write goes to address 0x55.
- R3: The tap write goes to address 0x55 and carries the tap value zero-extended to 16 bits. With STEP_BY_ONE = 0, bits [2:0] of that data are zero.
- R4: The final write of every request goes to address 0x11 with data 0x0000.
- R5: Each write raises drp_en and drp_we together for one DCLK cycle. No write is issued while an earlier write has not yet seen drp_rdy. The next write is issued on the edge that samples drp_rdy high.
- R6: With WAIT_DONE = 1, a one-cycle ps_done pulse in the ps_clk domain produces exactly one done pulse, 2 to 5 DCLK cycles after the ps_clk edge that captures it.
- R7: With WAIT_DONE = 1 and no completion pulse, timeout rises exactly to_limit + 1 DCLK edges after the edge that samples drp_rdy for the start write. It stays high until the next accepted request, which clears it on the accepting edge.
- R8: busy rises on the edge that accepts a request and falls in the same cycle in which done or timeout rises. A request presented while busy causes no writes.
- R9: With WAIT_DONE = 0, done rises on the edge that samples drp_rdy for the start write, and timeout never rises.
- R10: done is never high in two consecutive DCLK cycles.
- R11: A completion pulse that arrives while the block is idle, for example after a timeout, produces no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Reconfiguration bus clock; all control logic runs on it |
| rst | input | 1 | Synchronous active-high reset, dclk domain |
| ps_clk | input | 1 | Phase clock that owns the completion pulse |
| ps_rst | input | 1 | Synchronous active-high reset, ps_clk domain |
| ps_done | input | 1 | One-cycle completion pulse, ps_clk domain |
| req_valid | input | 1 | Request strobe; taken only while idle |
| req_taps | input | TAP_W | Requested tap count |
| req_mode_ready | input | 1 | High when direct phase mode is already selected |
| to_limit | input | TO_W | Completion wait limit in DCLK cycles |
| drp_addr | output | AW | Reconfiguration register address |
| drp_di | output | DW | Reconfiguration write data |
| drp_en | output | 1 | Access strobe, one cycle per write |
| drp_we | output | 1 | Write qualifier, high with drp_en |
| drp_rdy | input | 1 | Access acknowledge from the clock manager |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle success pulse |
| timeout | output | 1 | Sticky flag: the completion wait expired |

## Verification
Cycle timing is measured against the bus responder's own record of the cycle in which it raised ready. The next write must appear one edge later. Done without waiting also appears one edge later. Timeout must appear exactly to_limit + 1 edges later, which the bench counts as to_limit + 2 from the cycle in which ready was raised. The completion pulse crosses clock domains, so its done is checked against a window of 2 to 5 DCLK cycles from the phase clock edge that captured it, and the bench counts done pulses so that a lost or doubled pulse is caught. All outputs are sampled at the falling DCLK edge, after every register on the path has updated.

// File: rtl/ps_seq_pkg.sv
package ps_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE,
    ST_TAP,
    ST_GO,
    ST_WAIT
  } seq_state_t;

  // register addresses and the mode code the clock manager decodes
  localparam int unsigned REG_MODE_SEL     = 32'h56;
  localparam int unsigned REG_TAP_VAL      = 32'h55;
  localparam int unsigned REG_KICK         = 32'h11;
  localparam int unsigned MODE_DIRECT_CODE = 32'h00D;

  // tap groups when fine stepping is off
  localparam int unsigned COARSE_BITS = 3;

endpackage

// File: rtl/ps_pulse_sync.sv
module ps_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_pulse
);

  logic src_tog;
  always_ff @(posedge src_clk) begin
    if (src_rst)        src_tog <= 1'b0;
    else if (src_pulse) src_tog <= ~src_tog;
  end

  // STAGES flops for metastability, one more for edge detection
  logic [STAGES:0] chain;
  always_ff @(posedge dst_clk) begin
    if (dst_rst) chain <= '0;
    else         chain <= {chain[STAGES-1:0], src_tog};
  end

  assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/ps_wait_timer.sv
module ps_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != '1)   cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == limit);

endmodule

// File: rtl/ps_drp_write.sv
module ps_drp_write #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] drp_addr,
  output logic [DW-1:0] drp_di,
  output logic          drp_en,
  output logic          drp_we,
  input  logic          drp_rdy,
  output logic          ack
);

  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      drp_en   <= 1'b0;
      drp_we   <= 1'b0;
      drp_addr <= '0;
      drp_di   <= '0;
    end else begin
      drp_en <= start;
      drp_we <= start;
      if (start) begin
        drp_addr <= wr_addr;
        drp_di   <= wr_data;
        pending  <= 1'b1;
      end else if (drp_rdy) begin
        pending  <= 1'b0;
      end
    end
  end

  // a ready with nothing outstanding is ignored
  assign ack = pending && drp_rdy;

endmodule

// File: rtl/ps_direct_seq.sv
module ps_direct_seq
  import ps_seq_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 16,
  parameter int TAP_W       = 10,
  parameter int STEP_BY_ONE = 1,
  parameter int WAIT_DONE   = 1,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             dclk,
  input  logic             rst,
  input  logic             ps_clk,
  input  logic             ps_rst,
  input  logic             ps_done,
  input  logic             req_valid,
  input  logic [TAP_W-1:0] req_taps,
  input  logic             req_mode_ready,
  input  logic [TO_W-1:0]  to_limit,
  output logic [AW-1:0]    drp_addr,
  output logic [DW-1:0]    drp_di,
  output logic             drp_en,
  output logic             drp_we,
  input  logic             drp_rdy,
  output logic             busy,
  output logic             done,
  output logic             timeout
);

  localparam int GRAN_BITS = (STEP_BY_ONE != 0) ? 0 : COARSE_BITS;
  localparam logic [TAP_W-1:0] TAP_MASK = {TAP_W{1'b1}} << GRAN_BITS;
  localparam logic [AW-1:0] A_MODE = AW'(REG_MODE_SEL);
  localparam logic [AW-1:0] A_TAP  = AW'(REG_TAP_VAL);
  localparam logic [AW-1:0] A_KICK = AW'(REG_KICK);
  localparam logic [DW-1:0] D_MODE = DW'(MODE_DIRECT_CODE);

  seq_state_t st, st_n;
  logic [DW-1:0] taps_q;
  logic [DW-1:0] tap_word;
  logic          wr_start;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          wr_ack;
  logic          cpl_pulse;
  logic          wait_expired;
  logic          done_n;
  logic          to_set;
  logic          accept;

  assign tap_word = DW'(req_taps & TAP_MASK);
  assign accept   = (st == ST_IDLE) && req_valid;

  ps_drp_write #(.AW(AW), .DW(DW)) u_wr (
    .clk      (dclk),
    .rst      (rst),
    .start    (wr_start),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .drp_addr (drp_addr),
    .drp_di   (drp_di),
    .drp_en   (drp_en),
    .drp_we   (drp_we),
    .drp_rdy  (drp_rdy),
    .ack      (wr_ack)
  );

  ps_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .src_clk   (ps_clk),
    .src_rst   (ps_rst),
    .src_pulse (ps_done),
    .dst_clk   (dclk),
    .dst_rst   (rst),
    .dst_pulse (cpl_pulse)
  );

  ps_wait_timer #(.W(TO_W)) u_tmr (
    .clk     (dclk),
    .rst     (rst),
    .run     (st == ST_WAIT),
    .limit   (to_limit),
    .expired (wait_expired)
  );

  always_comb begin
    st_n     = st;
    wr_start = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    done_n   = 1'b0;
    to_set   = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          wr_start = 1'b1;
          if (req_mode_ready) begin
            wr_addr = A_TAP;
            wr_data = tap_word;
            st_n    = ST_TAP;
          end else begin
            wr_addr = A_MODE;
            wr_data = D_MODE;
            st_n    = ST_MODE;
          end
        end
      end
      ST_MODE: begin
        if (wr_ack) begin
          wr_start = 1'b1;
          wr_addr  = A_TAP;
          wr_data  = taps_q;
          st_n     = ST_TAP;
        end
      end
      ST_TAP: begin
        if (wr_ack) begin
          wr_start = 1'b1;
          wr_addr  = A_KICK;
          wr_data  = '0;
          st_n     = ST_GO;
        end
      end
      ST_GO: begin
        if (wr_ack) begin
          if (WAIT_DONE != 0) begin
            st_n = ST_WAIT;
          end else begin
            done_n = 1'b1;
            st_n   = ST_IDLE;
          end
        end
      end
      ST_WAIT: begin
        if (cpl_pulse) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else if (wait_expired) begin
          to_set = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge dclk) begin
    if (rst) begin
      st      <= ST_IDLE;
      taps_q  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      st   <= st_n;
      busy <= (st_n != ST_IDLE);
      done <= done_n;
      if (accept) begin
        taps_q  <= tap_word;
        timeout <= 1'b0;
      end else if (to_set) begin
        timeout <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/ps_direct_seq_chk.sv
module ps_direct_seq_chk #(
  parameter int AW          = 7,
  parameter int DW          = 16,
  parameter int STEP_BY_ONE = 1,
  parameter int WAIT_DONE   = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          drp_en,
  input logic [AW-1:0] drp_addr,
  input logic [DW-1:0] drp_di,
  input logic          busy,
  input logic          done,
  input logic          timeout
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy && !done && !timeout && !drp_en));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> busy);

  a_r5_write_in_request: assert property (@(posedge clk) disable iff (rst)
    drp_en |-> busy);

  a_r7_done_no_timeout: assert property (@(posedge clk) disable iff (rst)
    done |-> !timeout);

  a_r4_kick_zero: assert property (@(posedge clk) disable iff (rst)
    (drp_en && drp_addr == AW'(32'h11)) |-> (drp_di == '0));

  if (STEP_BY_ONE == 0) begin : g_coarse
    a_r3_coarse_mask: assert property (@(posedge clk) disable iff (rst)
      (drp_en && drp_addr == AW'(32'h55)) |-> (drp_di[2:0] == 3'b000));
  end

  if (WAIT_DONE == 0) begin : g_nowait
    a_r9_no_timeout: assert property (@(posedge clk) disable iff (rst)
      !timeout);
  end

endmodule

bind ps_direct_seq ps_direct_seq_chk #(
  .AW(AW), .DW(DW), .STEP_BY_ONE(STEP_BY_ONE), .WAIT_DONE(WAIT_DONE)
) u_chk (
  .clk       (dclk),
  .rst       (rst),
  .req_valid (req_valid),
  .drp_en    (drp_en),
  .drp_addr  (drp_addr),
  .drp_di    (drp_di),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout)
);

// File: tb/sim_ps_direct_seq.sv
module sim_ps_direct_seq;

  logic dclk = 1'b0;
  logic ps_clk = 1'b0;
  always #4 dclk = ~dclk;     // 125 MHz
  always #5 ps_clk = ~ps_clk; // unrelated phase clock

  logic rst = 1'b1;
  logic ps_done = 1'b0;
  logic req0 = 1'b0, req1 = 1'b0;
  logic [9:0] taps = '0;
  logic mode_rdy = 1'b0;
  logic [15:0] to_limit = 16'd100;

  logic [6:0]  addr0, addr1;
  logic [15:0] di0, di1;
  logic en0, we0, en1, we1;
  logic rdy0 = 1'b0, rdy1 = 1'b0;
  logic busy0, done0, to0, busy1, done1, to1;

  ps_direct_seq u0 (
    .dclk(dclk), .rst(rst), .ps_clk(ps_clk), .ps_rst(rst), .ps_done(ps_done),
    .req_valid(req0), .req_taps(taps), .req_mode_ready(mode_rdy), .to_limit(to_limit),
    .drp_addr(addr0), .drp_di(di0), .drp_en(en0), .drp_we(we0), .drp_rdy(rdy0),
    .busy(busy0), .done(done0), .timeout(to0)
  );

  ps_direct_seq #(.STEP_BY_ONE(0), .WAIT_DONE(0)) u1 (
    .dclk(dclk), .rst(rst), .ps_clk(1'b0), .ps_rst(rst), .ps_done(1'b0),
    .req_valid(req1), .req_taps(taps), .req_mode_ready(mode_rdy), .to_limit(to_limit),
    .drp_addr(addr1), .drp_di(di1), .drp_en(en1), .drp_we(we1), .drp_rdy(rdy1),
    .busy(busy1), .done(done1), .timeout(to1)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge dclk) cyc++;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // bus responder model, one per instance
  logic [6:0]  wa0[$], wa1[$];
  logic [15:0] wd0[$], wd1[$];
  int ec0[$], rc0[$], ec1[$], rc1[$];
  int lat0 = 0;
  int go0 = -1, go1 = -1;
  bit out0 = 0, out1 = 0;
  int cnt0 = 0, cnt1 = 0;
  logic [6:0] cur0, cur1;

  always @(negedge dclk) begin
    if (rdy0) begin rdy0 = 1'b0; out0 = 0; end
    if (en0) begin
      chk(!out0 && we0, "R5", "write issued while outstanding or without we", {out0, we0}, 1);
      wa0.push_back(addr0); wd0.push_back(di0); ec0.push_back(cyc);
      out0 = 1; cnt0 = lat0; cur0 = addr0;
    end
    if (out0 && !rdy0) begin
      if (cnt0 == 0) begin
        rdy0 = 1'b1; rc0.push_back(cyc);
        if (cur0 == 7'h11) go0 = cyc;
      end else cnt0--;
    end
  end

  always @(negedge dclk) begin
    if (rdy1) begin rdy1 = 1'b0; out1 = 0; end
    if (en1) begin
      chk(!out1 && we1, "R5", "u1 write issued while outstanding or without we", {out1, we1}, 1);
      wa1.push_back(addr1); wd1.push_back(di1); ec1.push_back(cyc);
      out1 = 1; cnt1 = 2; cur1 = addr1;
    end
    if (out1 && !rdy1) begin
      if (cnt1 == 0) begin
        rdy1 = 1'b1; rc1.push_back(cyc);
        if (cur1 == 7'h11) go1 = cyc;
      end else cnt1--;
    end
  end

  // output monitor
  int nd0 = 0, nd1 = 0, dc0 = -1, dc1 = -1, tc0 = -1;
  bit pd0 = 0, pd1 = 0, pt0 = 0, seen_to1 = 0;
  always @(negedge dclk) begin
    if (!rst) begin
      if (done0) begin
        chk(!pd0, "R10", "u0 done two cycles", 1, 0);
        chk(!busy0, "R8", "u0 busy with done", busy0, 0);
        nd0++; dc0 = cyc;
      end
      if (done1) begin
        chk(!pd1, "R10", "u1 done two cycles", 1, 0);
        nd1++; dc1 = cyc;
      end
      if (to0 && !pt0) begin
        tc0 = cyc;
        chk(!busy0, "R8", "u0 busy with timeout", busy0, 0);
      end
      if (to1) seen_to1 = 1;
    end
    pd0 = done0; pd1 = done1; pt0 = to0;
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge dclk); #1; end
  endtask

  task automatic clear_q();
    wa0.delete(); wd0.delete(); ec0.delete(); rc0.delete();
    wa1.delete(); wd1.delete(); ec1.delete(); rc1.delete();
    go0 = -1; go1 = -1;
  endtask

  int pc = 0;
  task automatic fire_ps();
    @(posedge ps_clk); #1 ps_done = 1'b1;
    @(posedge ps_clk); pc = cyc; #1 ps_done = 1'b0;
  endtask

  task automatic wait_writes0(input int n);
    for (int i = 0; i < 300 && wa0.size() < n; i++) step(1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    step(1);
    // R1: state under reset
    chk(!busy0 && !done0 && !to0 && !en0, "R1", "u0 outputs in reset", {busy0, done0, to0, en0}, 0);
    step(3);
    rst = 1'b0;
    step(1);
    chk(!busy0 && !done0 && !to0 && !en0, "R1", "u0 outputs after reset", {busy0, done0, to0, en0}, 0);
    chk(!busy1 && !done1 && !to1 && !en1, "R1", "u1 outputs after reset", {busy1, done1, to1, en1}, 0);

    // full sequence, zero-latency ready, completion arrives
    clear_q(); lat0 = 0; taps = 10'h2A5; mode_rdy = 1'b0; to_limit = 16'd200;
    req0 = 1'b1; step(1); req0 = 1'b0;
    chk(busy0, "R8", "busy after accept", busy0, 1);
    taps = 10'h011; req0 = 1'b1; step(1); req0 = 1'b0; // ignored while busy
    wait_writes0(3);
    step(4);
    chk(wa0.size() == 3, "R8", "write count with ignored request", wa0.size(), 3);
    chk(wa0[0] == 7'h56 && wd0[0] == 16'h000D, "R2", "mode write", {wa0[0], wd0[0]}, {7'h56, 16'h000D});
    chk(wa0[1] == 7'h55 && wd0[1] == 16'h02A5, "R3", "tap write", {wa0[1], wd0[1]}, {7'h55, 16'h02A5});
    chk(wa0[2] == 7'h11 && wd0[2] == 16'h0000, "R4", "start write", {wa0[2], wd0[2]}, {7'h11, 16'h0000});
    chk(ec0[1] == rc0[0] + 1, "R5", "second write after ready", ec0[1], rc0[0] + 1);
    chk(ec0[2] == rc0[1] + 1, "R5", "third write after ready", ec0[2], rc0[1] + 1);
    chk(busy0 && nd0 == 0, "R6", "waiting for completion", {busy0, nd0[3:0]}, 5'h10);
    n0 = nd0;
    fire_ps();
    for (int i = 0; i < 20 && nd0 == n0; i++) step(1);
    chk(nd0 == n0 + 1, "R6", "one done per pulse", nd0, n0 + 1);
    chk(dc0 - pc >= 2 && dc0 - pc <= 5, "R6", "done latency", dc0 - pc, 3);
    step(8);
    chk(nd0 == n0 + 1 && !busy0 && !to0, "R6", "single done and idle", nd0, n0 + 1);

    // mode already selected, slow ready, no completion -> timeout
    clear_q(); lat0 = 3; taps = 10'h3FF; mode_rdy = 1'b1; to_limit = 16'd5;
    n0 = nd0;
    req0 = 1'b1; step(1); req0 = 1'b0;
    wait_writes0(2);
    for (int i = 0; i < 60 && !to0; i++) step(1);
    chk(wa0.size() == 2, "R2", "mode write skipped", wa0.size(), 2);
    chk(wa0[0] == 7'h55 && wd0[0] == 16'h03FF, "R2", "first write is tap", {wa0[0], wd0[0]}, {7'h55, 16'h03FF});
    chk(wa0[1] == 7'h11 && wd0[1] == 16'h0000, "R4", "start write", {wa0[1], wd0[1]}, {7'h11, 16'h0000});
    chk(rc0[0] == ec0[0] + 3 && ec0[1] == rc0[0] + 1, "R5", "write held until ready", ec0[1], ec0[0] + 4);
    chk(tc0 == go0 + 7, "R7", "timeout cycle limit 5", tc0 - go0, 7);
    // R11: late completion while idle
    fire_ps();
    step(10);
    chk(nd0 == n0, "R11", "late pulse gives no done", nd0, n0);
    chk(to0 && !busy0, "R7", "timeout sticky", to0, 1);

    // new request clears timeout; limit zero
    clear_q(); lat0 = 1; taps = 10'h000; mode_rdy = 1'b1; to_limit = 16'd0;
    req0 = 1'b1; step(1); req0 = 1'b0;
    chk(!to0, "R7", "timeout cleared on accept", to0, 0);
    for (int i = 0; i < 60 && !to0; i++) step(1);
    chk(tc0 == go0 + 2, "R7", "timeout cycle limit 0", tc0 - go0, 2);

    // no-wait, coarse-step instance
    clear_q(); taps = 10'h3FF; mode_rdy = 1'b0;
    n0 = nd1;
    req1 = 1'b1; step(1); req1 = 1'b0;
    for (int i = 0; i < 100 && nd1 == n0; i++) step(1);
    chk(wa1.size() == 3, "R2", "u1 write count", wa1.size(), 3);
    chk(wa1[1] == 7'h55 && wd1[1] == 16'h03F8, "R3", "coarse mask 0x3FF", wd1[1], 16'h03F8);
    chk(dc1 == go1 + 1, "R9", "done on ready edge", dc1 - go1, 1);
    clear_q(); taps = 10'h007; mode_rdy = 1'b1;
    req1 = 1'b1; step(1); req1 = 1'b0;
    for (int i = 0; i < 100 && wa1.size() < 2; i++) step(1);
    step(6);
    chk(wa1[0] == 7'h55 && wd1[0] == 16'h0000, "R3", "coarse mask 0x007", wd1[0], 16'h0000);
    chk(!seen_to1 && !busy1, "R9", "u1 never times out", seen_to1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule